// File: doc/BRIEF.md
# Wide Vertical Clock Pulse Generator

This block drives the vertical phase clocks of an image-sensor timing path. A start trigger opens a pattern group: every output channel takes its own programmed start level, then flips at up to four programmed toggle positions measured in pixel clocks from the start. A repeat value closes the group. After that the outputs hold their levels until the next start.

Two counting modes exist. In standard mode a toggle value is a plain pixel count. In multiplier mode each toggle value is scaled by a shared length factor, so a 13-bit field can place an edge tens of millions of pixels after the start, in steps as coarse as the factor. The scaling uses a divide-by-length sub-counter that feeds a coarse counter. No hardware multiplier is used. The line strobe normally restarts the count. With sweep enabled the strobe is ignored, so pulses can run across line boundaries.

Top module: `vpg_top`

## Requirements
- R1: After synchronous reset every phase output is low and the generator is idle.
- R2: A start trigger sampled on an edge sets each channel output to that channel's start-polarity bit on that same edge, and restarts the elapsed count at zero.
- R3: With the mode bit low (standard mode) the length input is ignored. A channel flips on the edge at which the elapsed pixel count equals one of its toggle values.
- R4: With the mode bit high (multiplier mode) a channel flips when the elapsed count equals toggle value times length factor. For example, a factor of 4 with toggles 2 and 9 flips at pixels 8 and 36.
- R5: In multiplier mode a length factor of zero behaves as a factor of one.
- R6: A toggle value of zero, or one greater than the repeat value, never causes a transition.
- R7: The group ends on the edge at which the coarse count reaches the repeat value. A toggle equal to the repeat value still fires. Afterwards the outputs hold, line strobes included, until the next start.
- R8: With sweep disabled, a line strobe while running clears the elapsed count to zero without changing the outputs. Later toggles are measured from that strobe.
- R9: With sweep enabled, line strobes have no effect on counting.
- R10: Toggle slot k of channel c is bits [(c*4+k)*13 +: 13] of the toggle bus. All four slots are active. Slots holding the same value give a single transition.
- R11: A start arriving while a group runs restarts the group from zero at the start polarities.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Pattern group start trigger |
| hd_i | input | 1 | Line strobe |
| sweep_i | input | 1 | High: line strobe does not clear counting |
| mult_i | input | 1 | High: multiplier mode; low: standard mode |
| len_i | input | 13 | Length factor (multiplier mode) |
| rep_i | input | 13 | Repeat value, the end of the group in coarse units |
| pol_i | input | 4 | Start polarity per channel |
| tog_i | input | 208 | Four 13-bit toggle values per channel |
| v_o | output | 4 | Vertical phase outputs |

## Verification
The in-line assertions assume that the mode, length, repeat and toggle inputs change only while no group is running. The counter-range properties rest on that assumption. The stimulus writes a new configuration only after the previous group has passed its repeat point. Start and strobe pulses are free to arrive at any cycle, including together, where start wins. The scoreboard model works from elapsed pixels, multiplication and remainder. It does not mirror the sub-counter structure.

// File: rtl/vpg_pkg.sv
package vpg_pkg;

  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_MULT = 1'b1
  } vpg_mode_e;

  // A toggle slot is live only when it is nonzero and does not pass the end.
  function automatic logic slot_live(input int unsigned tog, input int unsigned rep);
    return (tog != 0) && (tog <= rep);
  endfunction

endpackage

// File: rtl/vpg_timebase.sv
module vpg_timebase #(
  parameter int POS_W = 13
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             hd_i,
  input  logic             sweep_i,
  input  logic             mult_i,
  input  logic [POS_W-1:0] len_i,
  input  logic [POS_W-1:0] rep_i,
  output logic             adv_o,
  output logic [POS_W:0]   crs_nxt_o,
  output logic             run_o
);
  import vpg_pkg::*;

  localparam logic [POS_W-1:0] ONE = POS_W'(1);

  logic [POS_W-1:0] len_eff;
  logic [POS_W-1:0] sub_q;
  logic [POS_W-1:0] crs_q;
  logic             run_q;
  logic             hd_clr;
  logic             wrap;

  always_comb begin
    if (vpg_mode_e'(mult_i) == MODE_MULT && len_i != '0) len_eff = len_i;
    else                                                 len_eff = ONE;
  end

  assign hd_clr    = hd_i && !sweep_i;
  assign wrap      = (sub_q == len_eff - ONE);
  assign crs_nxt_o = {1'b0, crs_q} + {{POS_W{1'b0}}, 1'b1};
  assign adv_o     = run_q && !start_i && !hd_clr && wrap;
  assign run_o     = run_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      sub_q <= '0;
      crs_q <= '0;
      run_q <= 1'b0;
    end else if (start_i) begin
      sub_q <= '0;
      crs_q <= '0;
      run_q <= 1'b1;
    end else if (hd_clr) begin
      sub_q <= '0;
      crs_q <= '0;
    end else if (run_q) begin
      if (wrap) begin
        sub_q <= '0;
        crs_q <= crs_nxt_o[POS_W-1:0];
        if (crs_nxt_o >= {1'b0, rep_i}) run_q <= 1'b0;
      end else begin
        sub_q <= sub_q + ONE;
      end
    end
  end

  // R8
  hd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (hd_i && !sweep_i && !start_i) |=> (sub_q == '0 && crs_q == '0));

  // R9
  sweep_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (run_q && hd_i && sweep_i && !start_i && !wrap) |=> (sub_q == $past(sub_q) + ONE));

  // R7
  crs_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (crs_q <= rep_i));

  // R5
  sub_window_chk: assert property (@(posedge clk) disable iff (rst)
    run_q |-> (sub_q < len_eff));

endmodule

// File: rtl/vpg_tog_match.sv
module vpg_tog_match #(
  parameter int POS_W   = 13,
  parameter int NUM_TOG = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_TOG*POS_W-1:0]   tog_i,
  input  logic [POS_W-1:0]           rep_i,
  input  logic                       adv_i,
  input  logic [POS_W:0]             crs_nxt_i,
  output logic                       hit_o
);
  import vpg_pkg::*;

  logic [NUM_TOG-1:0] slot_hit;

  for (genvar k = 0; k < NUM_TOG; k++) begin : g_slot
    logic [POS_W-1:0] tv;
    assign tv = tog_i[k*POS_W +: POS_W];
    assign slot_hit[k] = slot_live(int'(tv), int'(rep_i)) &&
                         ({1'b0, tv} == crs_nxt_i);
  end

  assign hit_o = adv_i && (|slot_hit);

  // R6
  hit_needs_adv_chk: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> (adv_i && crs_nxt_i <= {1'b0, rep_i} && crs_nxt_i != '0));

endmodule

// File: rtl/vpg_phase_reg.sv
module vpg_phase_reg (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic pol_i,
  input  logic hit_i,
  output logic v_o
);

  logic v_q;

  always_ff @(posedge clk) begin
    if (rst)          v_q <= 1'b0;
    else if (start_i) v_q <= pol_i;
    else if (hit_i)   v_q <= ~v_q;
  end

  assign v_o = v_q;

  // R2
  start_pol_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (v_q == $past(pol_i)));

  // R3
  flip_chk: assert property (@(posedge clk) disable iff (rst)
    (hit_i && !start_i) |=> (v_q != $past(v_q)));

endmodule

// File: rtl/vpg_top.sv
module vpg_top #(
  parameter int POS_W   = 13,
  parameter int NUM_CH  = 4,
  parameter int NUM_TOG = 4
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              start_i,
  input  logic                              hd_i,
  input  logic                              sweep_i,
  input  logic                              mult_i,
  input  logic [POS_W-1:0]                  len_i,
  input  logic [POS_W-1:0]                  rep_i,
  input  logic [NUM_CH-1:0]                 pol_i,
  input  logic [NUM_CH*NUM_TOG*POS_W-1:0]   tog_i,
  output logic [NUM_CH-1:0]                 v_o
);

  localparam int CH_BITS = NUM_TOG * POS_W;

  logic           adv;
  logic [POS_W:0] crs_nxt;
  logic           run;
  logic [NUM_CH-1:0] hit;

  vpg_timebase #(.POS_W(POS_W)) u_tb (
    .clk       (clk),
    .rst       (rst),
    .start_i   (start_i),
    .hd_i      (hd_i),
    .sweep_i   (sweep_i),
    .mult_i    (mult_i),
    .len_i     (len_i),
    .rep_i     (rep_i),
    .adv_o     (adv),
    .crs_nxt_o (crs_nxt),
    .run_o     (run)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    vpg_tog_match #(.POS_W(POS_W), .NUM_TOG(NUM_TOG)) u_match (
      .clk       (clk),
      .rst       (rst),
      .tog_i     (tog_i[c*CH_BITS +: CH_BITS]),
      .rep_i     (rep_i),
      .adv_i     (adv),
      .crs_nxt_i (crs_nxt),
      .hit_o     (hit[c])
    );

    vpg_phase_reg u_phase (
      .clk     (clk),
      .rst     (rst),
      .start_i (start_i),
      .pol_i   (pol_i[c]),
      .hit_i   (hit[c]),
      .v_o     (v_o[c])
    );
  end

  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!run && !start_i) |=> $stable(v_o));

  // R1
  reset_low_chk: assert property (@(posedge clk)
    rst |=> (v_o == '0 && !run));

endmodule

// File: tb/vpg_top_tb.sv
module vpg_top_tb;

  localparam int POS_W = 13;
  localparam int NCH   = 4;
  localparam int NTOG  = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 1'b0;
  logic hd_i = 1'b0;
  logic sweep_i = 1'b0;
  logic mult_i = 1'b0;
  logic [POS_W-1:0] len_i = '0;
  logic [POS_W-1:0] rep_i = '0;
  logic [NCH-1:0] pol_i = '0;
  logic [NCH*NTOG*POS_W-1:0] tog_i = '0;
  logic [NCH-1:0] v_o;

  int checks = 0;
  int errors = 0;

  // model state
  int m_e = 0;
  bit m_run = 1'b0;
  logic [NCH-1:0] m_v = '0;

  logic [NCH-1:0] exp_q[$];
  string          tag_q[$];

  always #10 clk = ~clk;

  vpg_top #(.POS_W(POS_W), .NUM_CH(NCH), .NUM_TOG(NTOG)) u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .hd_i(hd_i), .sweep_i(sweep_i),
    .mult_i(mult_i), .len_i(len_i), .rep_i(rep_i), .pol_i(pol_i),
    .tog_i(tog_i), .v_o(v_o)
  );

  task automatic put_tog(input int c, input int k, input int val);
    tog_i[(c*NTOG+k)*POS_W +: POS_W] = POS_W'(val);
  endtask

  task automatic clear_togs();
    tog_i = '0;
  endtask

  function automatic int get_tog(input int c, input int k);
    return int'(tog_i[(c*NTOG+k)*POS_W +: POS_W]);
  endfunction

  // Driver: applies one cycle of stimulus and pushes the expected output.
  task automatic step(input bit st, input bit hd, input string tag);
    int l;
    int k;
    logic [NCH-1:0] flip;
    @(negedge clk);
    start_i = st;
    hd_i    = hd;
    l = (mult_i && len_i != 0) ? int'(len_i) : 1;
    if (st) begin
      m_e = 0; m_run = 1'b1; m_v = pol_i;
    end else if (hd && !sweep_i) begin
      m_e = 0;
    end else if (m_run) begin
      m_e++;
      if (m_e % l == 0) begin
        k = m_e / l;
        flip = '0;
        for (int c = 0; c < NCH; c++)
          for (int t = 0; t < NTOG; t++)
            if (get_tog(c, t) != 0 && get_tog(c, t) <= int'(rep_i) && get_tog(c, t) == k)
              flip[c] = 1'b1;
        m_v = m_v ^ flip;
        if (k >= int'(rep_i)) m_run = 1'b0;
      end
    end
    exp_q.push_back(m_v);
    tag_q.push_back(tag);
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, tag);
  endtask

  // Monitor: compares away from the active edge.
  always @(posedge clk) begin
    #5;
    if (exp_q.size() > 0) begin
      logic [NCH-1:0] ex;
      string tg;
      ex = exp_q.pop_front();
      tg = tag_q.pop_front();
      checks++;
      if (v_o !== ex) begin
        errors++;
        $display("FAIL %s: v_o=%b expected %b", tg, v_o, ex);
      end
    end
  end

  initial begin
    #(20 * 200000);
    errors++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    checks++;
    if (v_o !== '0) begin
      errors++;
      $display("FAIL R1: v_o=%b expected %b", v_o, 4'b0000);
    end
    rst = 1'b0;
    idle(2, "R1");

    // Standard mode; length ignored (R3), disabled slots (R6), four slots (R10)
    mult_i = 1'b0; len_i = 7; rep_i = 20; sweep_i = 1'b0;
    pol_i = 4'b0010; clear_togs();
    put_tog(0, 0, 3);  put_tog(0, 1, 10);
    put_tog(1, 2, 5);
    put_tog(2, 0, 25); put_tog(2, 3, 20);  // R6 (25 disabled), R7 (20 at end)
    put_tog(3, 0, 1); put_tog(3, 1, 2); put_tog(3, 2, 4); put_tog(3, 3, 8);
    step(1'b1, 1'b0, "R2");
    idle(30, "R3");
    step(1'b0, 1'b1, "R7");  // strobe after end: no effect
    idle(3, "R7");

    // Multiplier mode with sweep, strobes ignored (R4, R9, R10 duplicates)
    mult_i = 1'b1; len_i = 4; rep_i = 9; sweep_i = 1'b1;
    pol_i = 4'b0101; clear_togs();
    put_tog(0, 0, 2); put_tog(0, 1, 9);
    put_tog(1, 0, 9); put_tog(1, 1, 9);    // R10 duplicate slots
    put_tog(2, 0, 0); put_tog(2, 1, 10);   // R6 both disabled
    put_tog(3, 3, 5);
    step(1'b1, 1'b0, "R2");
    for (int i = 1; i <= 44; i++) step(1'b0, (i % 10) == 0, "R4 R9");

    // Length zero acts as one (R5)
    len_i = 0; rep_i = 5; sweep_i = 1'b0; pol_i = 4'b1111; clear_togs();
    put_tog(0, 0, 3); put_tog(1, 0, 5); put_tog(2, 0, 1); put_tog(3, 0, 6);
    step(1'b1, 1'b0, "R5");
    idle(8, "R5");

    // Strobe without sweep restarts counting (R8)
    len_i = 3; rep_i = 10; sweep_i = 1'b0; pol_i = 4'b0000; clear_togs();
    put_tog(0, 0, 4); put_tog(1, 0, 1); put_tog(2, 0, 10); put_tog(3, 0, 2);
    step(1'b1, 1'b0, "R8");
    idle(5, "R8");
    step(1'b0, 1'b1, "R8");
    idle(7, "R8");
    step(1'b1, 1'b1, "R8");  // start and strobe together: start wins
    idle(4, "R8");
    step(1'b0, 1'b1, "R8");
    idle(36, "R8");

    // Restart mid-run (R11)
    len_i = 2; rep_i = 4; pol_i = 4'b1001; clear_togs();
    put_tog(0, 0, 3); put_tog(1, 0, 1); put_tog(2, 0, 2); put_tog(3, 0, 4);
    step(1'b1, 1'b0, "R11");
    idle(4, "R11");
    pol_i = 4'b0110;
    step(1'b1, 1'b0, "R11");
    idle(12, "R11");

    @(negedge clk);
    @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule